// File: doc/BRIEF.md
# NOR Flash Operation Completion Poller

This block sits on the host side of an external parallel NOR flash. It decides when the flash has finished an embedded program or erase that the host has just started. The command writes come from another unit. The poller is armed with a start pulse before those writes begin, and it counts the end of each write strobe. Once the strobe that carries the final command byte has ended, it begins issuing bus reads through a simple request/acknowledge handshake.

Two completion methods are offered, chosen by a mode input that is latched at start. In toggle mode, the poller watches status bit 6 and declares completion when two consecutive reads return the same value; while the device is busy, that bit alternates. In data-polling mode, it watches status bit 7 until that bit reaches its target value. It then makes one confirming read and compares the whole word against the expected data. A programmable limit on the number of status reads turns a device that never finishes into an error. The result is reported as a single-cycle done pulse or a single-cycle error pulse, after which the block is idle again.

Top module: `nbp_poller`

## Requirements
- R1: After reset, and whenever reset is asserted, `done`, `error` and `rd_req` are low and the block is idle.
- R2: `start` is accepted only while idle. At that moment `use_toggle` (1 = toggle mode, 0 = data-polling mode), `op_erase` (1 = erase, 0 = program), `exp_data` and `poll_limit` are captured. A `start` pulse or input changes during an operation have no effect on it.
- R3: No read is requested until the high-to-low transition of `wr_strobe` number 4 (program) or number 6 (erase) counted since start. `rd_req` goes high in the cycle after that transition is sampled.
- R4: `rd_req` stays high until `rd_ack` is seen. Each cycle with both high is one read, and `rd_data` is taken in that cycle.
- R5: Toggle mode: completion is found when bit 6 of a read equals bit 6 of the read before it in the same operation. The first read is never a completion.
- R6: Data-polling mode: a status read meets the target when bit 7 equals bit 7 of the captured expected word (program), or equals 1 (erase).
- R7: Data-polling mode: after the target is met, exactly one more read is made. If the full word equals the captured expected word, the result is done; otherwise it is error.
- R8: Status reads are counted. If read number `poll_limit` does not show completion, error is raised and no further read is made. A completion on that read still gives done.
- R9: `done` and `error` are one-cycle pulses that are never high together. Each rises in the cycle after the deciding acknowledge, and the block is then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arm the poller for one operation |
| use_toggle | input | 1 | 1 = toggle-bit mode, 0 = data-polling mode |
| op_erase | input | 1 | 1 = erase, 0 = program |
| exp_data | input | DW | Word written by the program, or the erased value |
| poll_limit | input | CW | Maximum number of status reads |
| wr_strobe | input | 1 | Active-high write strobe of the command sequence |
| rd_req | output | 1 | Read request to the bus unit |
| rd_ack | input | 1 | Read acknowledge; `rd_data` valid in this cycle |
| rd_data | input | DW | Data returned by the read |
| done | output | 1 | One-cycle pulse: operation completed |
| error | output | 1 | One-cycle pulse: timeout or failed confirmation |

## Verification
The bus model answers reads from a busy/finished device model. Toggle mode is tried with the finished value of bit 6 both equal to and different from the last busy value, which separates a one-read from a two-read detection tail. It is also tried with a device that is already finished, so that the first read is shown not to count alone. Data-polling mode is tried with expected bit 7 at 0 and at 1 for program, and with erase, which proves the target follows the operation type. A corrupted confirming word separates the bit-7 check from the full compare. Never-finishing devices, and a completion landing exactly on the read limit, bound the timeout on both sides.

// File: rtl/nbp_pkg.sv
package nbp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HOLD    = 3'd1,
        ST_POLL    = 3'd2,
        ST_CONFIRM = 3'd3,
        ST_DONE    = 3'd4,
        ST_FAIL    = 3'd5
    } poll_st_e;

endpackage

// File: rtl/nbp_strobe_count.sv
// Counts ends of write strobes and flags the one that completes the command.
module nbp_strobe_count #(
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic          strobe,
    input  logic [SW-1:0] need,
    output logic          last_end
);
    typedef struct packed {
        logic          prev;
        logic [SW-1:0] cnt;
    } sc_t;

    sc_t q, d;
    logic fall;

    always_comb begin
        d      = q;
        fall   = q.prev && !strobe;
        d.prev = strobe;
        if (clear) begin
            d.cnt = '0;
        end else if (en && fall) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    assign last_end = en && fall && ((q.cnt + 1'b1) == need);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/nbp_status_eval.sv
// Decides from one status read whether the embedded operation looks finished.
module nbp_status_eval #(
    parameter int DW       = 16,
    parameter int TOG_BIT  = 6,
    parameter int POLL_BIT = 7
) (
    input  logic          use_toggle,
    input  logic          op_erase,
    input  logic          exp_poll,
    input  logic          have_prev,
    input  logic          prev_tog,
    input  logic [DW-1:0] rd_data,
    output logic          complete,
    output logic          cur_tog
);
    logic target;

    always_comb begin
        cur_tog = rd_data[TOG_BIT];
        target  = op_erase ? 1'b1 : exp_poll;
        if (use_toggle) begin
            complete = have_prev && (rd_data[TOG_BIT] == prev_tog);
        end else begin
            complete = (rd_data[POLL_BIT] == target);
        end
    end
endmodule

// File: rtl/nbp_poll_timer.sv
// Counts status reads and flags the read that reaches the limit.
module nbp_poll_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    input  logic [CW-1:0] limit,
    output logic          at_limit
);
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW:0]   nxt;

    always_comb begin
        nxt   = {1'b0, cnt_q} + 1'b1;
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = nxt[CW-1:0];
        end
    end

    assign at_limit = (nxt >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/nbp_poller.sv
module nbp_poller #(
    parameter int DW            = 16,
    parameter int CW            = 8,
    parameter int TOG_BIT       = 6,
    parameter int POLL_BIT      = 7,
    parameter int PROG_STROBES  = 4,
    parameter int ERASE_STROBES = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          use_toggle,
    input  logic          op_erase,
    input  logic [DW-1:0] exp_data,
    input  logic [CW-1:0] poll_limit,
    input  logic          wr_strobe,
    output logic          rd_req,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          done,
    output logic          error
);
    import nbp_pkg::*;

    localparam int MAXS = (ERASE_STROBES > PROG_STROBES) ? ERASE_STROBES : PROG_STROBES;
    localparam int SW   = $clog2(MAXS + 1);

    typedef struct packed {
        poll_st_e      st;
        logic          use_tog;
        logic          erase;
        logic [DW-1:0] exp;
        logic [CW-1:0] limit;
        logic          prev_tog;
        logic          have_prev;
    } regs_t;

    regs_t q, d;
    poll_st_e st_q;

    logic          stb_clear, stb_en, stb_last;
    logic          tmr_clear, tmr_inc, at_limit;
    logic          complete, cur_tog;
    logic [SW-1:0] need;

    assign st_q = q.st;
    assign need = q.erase ? SW'(ERASE_STROBES) : SW'(PROG_STROBES);

    nbp_strobe_count #(.SW(SW)) u_stb (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (stb_clear),
        .en       (stb_en),
        .strobe   (wr_strobe),
        .need     (need),
        .last_end (stb_last)
    );

    nbp_poll_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tmr_clear),
        .inc      (tmr_inc),
        .limit    (q.limit),
        .at_limit (at_limit)
    );

    nbp_status_eval #(
        .DW       (DW),
        .TOG_BIT  (TOG_BIT),
        .POLL_BIT (POLL_BIT)
    ) u_eval (
        .use_toggle (q.use_tog),
        .op_erase   (q.erase),
        .exp_poll   (q.exp[POLL_BIT]),
        .have_prev  (q.have_prev),
        .prev_tog   (q.prev_tog),
        .rd_data    (rd_data),
        .complete   (complete),
        .cur_tog    (cur_tog)
    );

    always_comb begin
        d         = q;
        stb_clear = 1'b0;
        stb_en    = 1'b0;
        tmr_clear = 1'b0;
        tmr_inc   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                stb_clear = 1'b1;
                tmr_clear = 1'b1;
                if (start) begin
                    d.st        = ST_HOLD;
                    d.use_tog   = use_toggle;
                    d.erase     = op_erase;
                    d.exp       = exp_data;
                    d.limit     = poll_limit;
                    d.have_prev = 1'b0;
                    d.prev_tog  = 1'b0;
                end
            end
            ST_HOLD: begin
                stb_en = 1'b1;
                if (stb_last) begin
                    d.st = ST_POLL;
                end
            end
            ST_POLL: begin
                if (rd_ack) begin
                    tmr_inc     = 1'b1;
                    d.prev_tog  = cur_tog;
                    d.have_prev = 1'b1;
                    if (complete) begin
                        d.st = q.use_tog ? ST_DONE : ST_CONFIRM;
                    end else if (at_limit) begin
                        d.st = ST_FAIL;
                    end
                end
            end
            ST_CONFIRM: begin
                if (rd_ack) begin
                    d.st = (rd_data == q.exp) ? ST_DONE : ST_FAIL;
                end
            end
            ST_DONE, ST_FAIL: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    assign rd_req = (q.st == ST_POLL) || (q.st == ST_CONFIRM);
    assign done   = (q.st == ST_DONE);
    assign error  = (q.st == ST_FAIL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/nbp_checker.sv
module nbp_checker #(
    parameter int PROG_STROBES  = 4,
    parameter int ERASE_STROBES = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              op_erase,
    input logic              wr_strobe,
    input logic              rd_req,
    input logic              rd_ack,
    input logic              done,
    input logic              error,
    input nbp_pkg::poll_st_e st_q
);
    import nbp_pkg::*;

    logic       ck_prev_q;
    logic [3:0] ck_falls_q;
    logic [3:0] ck_need_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_prev_q  <= 1'b0;
            ck_falls_q <= '0;
            ck_need_q  <= 4'(ERASE_STROBES);
        end else begin
            ck_prev_q <= wr_strobe;
            if (st_q == ST_IDLE && start) begin
                ck_falls_q <= '0;
                ck_need_q  <= op_erase ? 4'(ERASE_STROBES) : 4'(PROG_STROBES);
            end else if (ck_prev_q && !wr_strobe && ck_falls_q != 4'hF) begin
                ck_falls_q <= ck_falls_q + 1'b1;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_IDLE) |-> (!rd_req && !done && !error)); // R1
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> (ck_falls_q >= ck_need_q)); // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (rd_req && !rd_ack) |=> rd_req); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) error |=> !error); // R9
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && error)); // R9
    AST_RESULT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(rd_ack)); // R9
endmodule

bind nbp_poller nbp_checker #(
    .PROG_STROBES  (PROG_STROBES),
    .ERASE_STROBES (ERASE_STROBES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_erase  (op_erase),
    .wr_strobe (wr_strobe),
    .rd_req    (rd_req),
    .rd_ack    (rd_ack),
    .done      (done),
    .error     (error),
    .st_q      (st_q)
);

// File: tb/tb_nbp_poller.sv
module tb_nbp_poller;
    localparam int CLK_P = 10;
    localparam int DW    = 16;
    localparam int CW    = 8;

    typedef struct packed {
        logic       tog;
        logic       ers;
        logic [15:0] exp;
        logic [7:0] busy;
        logic       bad;
        logic [7:0] limit;
        logic       want_done;
        logic [7:0] want_reads;
    } vec_t;

    // tog, ers, exp, busy reads, bad confirm, limit, expect done, expect reads
    localparam vec_t VECS [12] = '{
        '{1'b1, 1'b0, 16'h00C3, 8'd3,  1'b0, 8'd20, 1'b1, 8'd4},  // R5 finished bit6 equals last busy+1
        '{1'b1, 1'b1, 16'hFFFF, 8'd2,  1'b0, 8'd20, 1'b1, 8'd4},  // R5 two-read tail
        '{1'b1, 1'b0, 16'h1234, 8'd2,  1'b0, 8'd20, 1'b1, 8'd3},  // R5 one-read tail
        '{1'b1, 1'b0, 16'h0040, 8'd0,  1'b0, 8'd20, 1'b1, 8'd2},  // R5 already finished
        '{1'b0, 1'b0, 16'h0080, 8'd3,  1'b0, 8'd20, 1'b1, 8'd5},  // R6 program bit7=1
        '{1'b0, 1'b0, 16'h5A11, 8'd1,  1'b0, 8'd20, 1'b1, 8'd3},  // R6 program bit7=0
        '{1'b0, 1'b1, 16'hFFFF, 8'd4,  1'b0, 8'd20, 1'b1, 8'd6},  // R6 erase
        '{1'b0, 1'b0, 16'h00AA, 8'd0,  1'b1, 8'd20, 1'b0, 8'd2},  // R7 bad confirm
        '{1'b1, 1'b0, 16'h1234, 8'd10, 1'b0, 8'd5,  1'b0, 8'd5},  // R8 toggle timeout
        '{1'b0, 1'b0, 16'h0080, 8'd10, 1'b0, 8'd3,  1'b0, 8'd3},  // R8 polling timeout
        '{1'b1, 1'b0, 16'h1234, 8'd2,  1'b0, 8'd3,  1'b1, 8'd3},  // R8 completion on last read
        '{1'b1, 1'b0, 16'h1234, 8'd2,  1'b0, 8'd2,  1'b0, 8'd2}   // R8 limit one short
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          use_toggle = 1'b0;
    logic          op_erase = 1'b0;
    logic [DW-1:0] exp_data = '0;
    logic [CW-1:0] poll_limit = '0;
    logic          wr_strobe = 1'b0;
    logic          rd_req;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          done;
    logic          error;

    int nchk = 0;
    int nerr = 0;

    logic          cur_tog = 1'b0;
    logic          cur_ers = 1'b0;
    logic [DW-1:0] cur_exp = '0;
    int            cur_busy = 0;
    logic          cur_bad = 1'b0;
    int            rd_idx = 0;

    always #(CLK_P/2) clk = ~clk;

    nbp_poller #(.DW(DW), .CW(CW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .use_toggle (use_toggle),
        .op_erase   (op_erase),
        .exp_data   (exp_data),
        .poll_limit (poll_limit),
        .wr_strobe  (wr_strobe),
        .rd_req     (rd_req),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .done       (done),
        .error      (error)
    );

    function automatic logic [DW-1:0] dev_word(input int i);
        logic [DW-1:0] w;
        if (i < cur_busy) begin
            w = 16'(i * 16'h0111) & 16'hFF3F;
            if (cur_tog) w[6] = (i % 2 == 0);
            else         w[7] = cur_ers ? 1'b0 : ~cur_exp[7];
        end else if (cur_bad && i > cur_busy) begin
            w = cur_exp ^ 16'h0100;
        end else begin
            w = cur_exp;
        end
        return w;
    endfunction

    // Bus responder: acknowledges one cycle out of two while a read is requested.
    always @(negedge clk) begin
        if (!rst_n || rd_ack) begin
            rd_ack = 1'b0;
        end else if (rd_req) begin
            rd_data = dev_word(rd_idx);
            rd_ack  = 1'b1;
            rd_idx  = rd_idx + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic run_op(input vec_t v, input bit inject);
        int need;
        int waited;
        bit got_done;
        bit got_err;
        need     = v.ers ? 6 : 4;
        cur_tog  = v.tog;
        cur_ers  = v.ers;
        cur_exp  = v.exp;
        cur_busy = int'(v.busy);
        cur_bad  = v.bad;
        rd_idx   = 0;
        @(negedge clk);
        use_toggle = v.tog;
        op_erase   = v.ers;
        exp_data   = v.exp;
        poll_limit = v.limit;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        // R2: captured values must not follow later input changes
        exp_data   = ~v.exp;
        poll_limit = 8'd1;
        use_toggle = ~v.tog;
        op_erase   = ~v.ers;
        for (int k = 0; k < need; k++) begin
            wr_strobe = 1'b1;
            if (inject && k == 1) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(rd_req == 1'b0, "R3 no read before last strobe ends", int'(rd_req), 0);
            wr_strobe = 1'b0;
            @(negedge clk);
        end
        chk(rd_req == 1'b1, "R3 read requested after last strobe", int'(rd_req), 1);
        got_done = 1'b0;
        got_err  = 1'b0;
        waited   = 0;
        while (!got_done && !got_err && waited < 400) begin
            chk(!(done && error), "R9 done and error exclusive", int'(done), 0);
            got_done = done;
            got_err  = error;
            if (!got_done && !got_err) begin
                @(negedge clk);
                waited++;
            end
        end
        if (v.tog) chk(got_done == v.want_done, "R5/R8 toggle outcome", int'(got_done), int'(v.want_done));
        else if (v.bad) chk(got_done == v.want_done, "R7 confirm outcome", int'(got_done), int'(v.want_done));
        else chk(got_done == v.want_done, "R6/R8 polling outcome", int'(got_done), int'(v.want_done));
        chk(got_done || got_err, "R8 result before watchdog", 0, 1);
        chk(rd_idx == int'(v.want_reads), "R4/R8 read count", rd_idx, int'(v.want_reads));
        @(negedge clk);
        chk(!done && !error && !rd_req, "R9 pulse one cycle then idle", int'({done, error, rd_req}), 0);
        @(negedge clk);
        chk(rd_idx == int'(v.want_reads), "R8 no read after result", rd_idx, int'(v.want_reads));
    endtask

    initial begin
        #(CLK_P * 100000);
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !error && !rd_req, "R1 reset outputs low", int'({done, error, rd_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !error && !rd_req, "R1 idle after reset", int'({done, error, rd_req}), 0);

        for (int i = 0; i < 12; i++) begin
            run_op(VECS[i], 1'b0);
        end

        // R2: start pulsed mid-command with other mode and operation is ignored
        run_op(VECS[4], 1'b1);
        run_op(VECS[1], 1'b1);

        // R1: reset during polling clears outputs, block then works normally
        cur_tog = 1'b1; cur_ers = 1'b0; cur_exp = 16'h1234; cur_busy = 50; cur_bad = 1'b0; rd_idx = 0;
        @(negedge clk);
        use_toggle = 1'b1; op_erase = 1'b0; exp_data = 16'h1234; poll_limit = 8'd100; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            wr_strobe = 1'b1; @(negedge clk);
            wr_strobe = 1'b0; @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(rd_req == 1'b1, "R4 polling in progress", int'(rd_req), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!done && !error && !rd_req, "R1 reset mid-operation", int'({done, error, rd_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(VECS[2], 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule